// File: doc/BRIEF.md
# Dual-Issue Pairing and Hazard Checker

This block is the issue-control stage of an in-order core that can start two instructions per cycle. Each cycle it looks at up to two decoded instructions, older one in slot 0, and decides how many of them start. Each one that starts is steered to one execution port. The decision uses only the instruction class, a precision flag, and the state of three long-running iterative units. Operand readiness, register files and the datapaths belong elsewhere.

The core has two pipes. The memory pipe has a single adder that also generates addresses. The other pipe holds an integer adder, a branch unit, an integer multiply/divide port and three floating-point units, and only one of them can be used in a cycle. A branch closes the issue group. Serialising classes take the whole cycle.

The integer multiply/divide unit, the FP divide/square-root unit and the FP multiply unit each have a busy counter. A counter is loaded when a user of that unit issues and counts down once per cycle. Any later user of the unit is held until the counter reaches zero.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Encodings. Class codes: 0 integer ALU, 1 load, 2 store, 3 coprocessor transfer, 4 integer multiply/multiply-add, 5 integer divide, 6 HI/LO move, 7 branch/jump/call, 8 FP quick (negate, compare, abs, move), 9 FP add, 10 FP convert, 11 FP multiply/multiply-add, 12 FP divide/sqrt, 13 FP reciprocal sqrt, 14 serialising, 15 reserved (treated as serialising). Port bits: 0 memory-pipe adder, 1 other-pipe integer adder, 2 branch, 3 integer multiply/divide, 4 FP adder, 5 FP multiplier, 6 FP divide/sqrt, 7 solo (whole cycle). A granted slot has exactly one port bit set and an ungranted slot has none. Busy bits: 0 integer multiply/divide, 1 FP divide/sqrt, 2 FP multiply.
- R2: Issue is in order. Slot 1 is granted only if slot 0 is granted in the same cycle. An invalid slot 0 grants nothing. The stall output is high exactly when a valid slot is not granted.
- R3: Only classes 0 to 3 may use the memory pipe, and loads and stores may use nothing else. Two instructions pair only if one can go to each pipe. When both assignments work, slot 0 takes the memory pipe. A lone class 0 or 3 instruction goes to the memory pipe.
- R4: At most one other-pipe port is used per cycle. Classes 0 and 3 go to bit 1, 4 to 6 to bit 3, 8 to 10 to bit 4, 11 to bit 5, and 12 and 13 to bit 6 when they use that pipe.
- R5: When a branch is granted in slot 0, slot 1 is not granted. A branch in slot 1 may pair with a memory-pipe instruction in slot 0.
- R6: A serialising class in slot 0 issues alone on the solo port. A serialising class in slot 1 is never granted alongside slot 0.
- R7: The integer multiply/divide unit is busy for 3 cycles after a 32-bit multiply, 8 after a 64-bit multiply, 36 after a 32-bit divide and 68 after a 64-bit divide. Classes 4 to 6 are held while it is busy.
- R8: The FP divide/sqrt unit is busy for 21 cycles after a single-precision divide/sqrt, 36 after a double-precision one, 38 after a single-precision reciprocal sqrt and 68 after a double-precision one. Classes 12 and 13 are held while it is busy.
- R9: The FP multiply unit is busy for 1 cycle after a single-precision multiply and 2 cycles after a double-precision one. Class 11 is held while it is busy.
- R10: Reset clears all three busy counters.
- R11: A HI/LO move uses port bit 3. It is held while the multiply/divide unit is busy, and it does not make that unit busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| valid0 | input | 1 | Older instruction present |
| class0 | input | 4 | Class code of older instruction |
| wide0 | input | 1 | Older instruction is 64-bit / double precision |
| valid1 | input | 1 | Younger instruction present |
| class1 | input | 4 | Class code of younger instruction |
| wide1 | input | 1 | Younger instruction is 64-bit / double precision |
| grant0 | output | 1 | Older instruction issues this cycle |
| grant1 | output | 1 | Younger instruction issues this cycle |
| port0 | output | 8 | One-hot port of older instruction |
| port1 | output | 8 | One-hot port of younger instruction |
| stall | output | 1 | A valid instruction was held |
| unitBusy | output | 3 | Busy flags of the iterative units |

## Verification
The bench builds the block with every latency at its default value. This means the full 68-cycle windows and the 7-bit counters that result from them are exercised. The windows are checked cycle by cycle as back-to-back users of the same unit are released. Holding the same divide or reciprocal sqrt in slot 0 shows the exact release cycle. The one-cycle FP multiply window shows the shortest count-down, where a counter loads and empties again in one step.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  localparam int CLS_W     = 4;
  localparam int NUM_ITER  = 3;
  localparam int NUM_PORTS = 8;

  localparam int ITER_MD = 0;
  localparam int ITER_FD = 1;
  localparam int ITER_FM = 2;

  localparam int P_MEM  = 0;
  localparam int P_IADD = 1;
  localparam int P_BR   = 2;
  localparam int P_MD   = 3;
  localparam int P_FADD = 4;
  localparam int P_FMUL = 5;
  localparam int P_FDIV = 6;
  localparam int P_SOLO = 7;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 4'd0,
    CLS_LOAD   = 4'd1,
    CLS_STORE  = 4'd2,
    CLS_XFER   = 4'd3,
    CLS_IMUL   = 4'd4,
    CLS_IDIV   = 4'd5,
    CLS_HILO   = 4'd6,
    CLS_BRANCH = 4'd7,
    CLS_FQUICK = 4'd8,
    CLS_FADD   = 4'd9,
    CLS_FCVT   = 4'd10,
    CLS_FMUL   = 4'd11,
    CLS_FDIV   = 4'd12,
    CLS_FRSQRT = 4'd13,
    CLS_SERIAL = 4'd14,
    CLS_RSVD   = 4'd15
  } instClass_e;

  // Strobes from control to the busy-counter datapath, one bit per unit.
  typedef struct packed {
    logic [NUM_ITER-1:0] load;
    logic [NUM_ITER-1:0] kind;
    logic [NUM_ITER-1:0] wide;
  } iterStrobe_t;

  function automatic logic isSerial(input logic [CLS_W-1:0] c);
    return (instClass_e'(c) == CLS_SERIAL) || (instClass_e'(c) == CLS_RSVD);
  endfunction

  function automatic logic memOk(input logic [CLS_W-1:0] c);
    case (instClass_e'(c))
      CLS_ALU, CLS_LOAD, CLS_STORE, CLS_XFER: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  function automatic logic fOk(input logic [CLS_W-1:0] c);
    case (instClass_e'(c))
      CLS_LOAD, CLS_STORE, CLS_SERIAL, CLS_RSVD: return 1'b0;
      default:                                   return 1'b1;
    endcase
  endfunction

  function automatic logic [NUM_PORTS-1:0] fPortVec(input logic [CLS_W-1:0] c);
    logic [NUM_PORTS-1:0] v;
    v = '0;
    case (instClass_e'(c))
      CLS_ALU, CLS_XFER:              v[P_IADD] = 1'b1;
      CLS_BRANCH:                     v[P_BR]   = 1'b1;
      CLS_IMUL, CLS_IDIV, CLS_HILO:   v[P_MD]   = 1'b1;
      CLS_FQUICK, CLS_FADD, CLS_FCVT: v[P_FADD] = 1'b1;
      CLS_FMUL:                       v[P_FMUL] = 1'b1;
      CLS_FDIV, CLS_FRSQRT:           v[P_FDIV] = 1'b1;
      default:                        v         = '0;
    endcase
    return v;
  endfunction

  // Iterative unit an instruction waits on.
  function automatic logic [NUM_ITER-1:0] unitMask(input logic [CLS_W-1:0] c);
    logic [NUM_ITER-1:0] m;
    m = '0;
    case (instClass_e'(c))
      CLS_IMUL, CLS_IDIV, CLS_HILO: m[ITER_MD] = 1'b1;
      CLS_FDIV, CLS_FRSQRT:         m[ITER_FD] = 1'b1;
      CLS_FMUL:                     m[ITER_FM] = 1'b1;
      default:                      m          = '0;
    endcase
    return m;
  endfunction

  // Iterative unit an instruction occupies once issued.
  function automatic logic [NUM_ITER-1:0] loadMask(input logic [CLS_W-1:0] c);
    return (instClass_e'(c) == CLS_HILO) ? '0 : unitMask(c);
  endfunction

  function automatic logic longKind(input logic [CLS_W-1:0] c);
    return (instClass_e'(c) == CLS_IDIV) || (instClass_e'(c) == CLS_FRSQRT);
  endfunction

endpackage

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic                 valid0,
  input  logic [CLS_W-1:0]     cls0,
  input  logic                 wide0,
  input  logic                 valid1,
  input  logic [CLS_W-1:0]     cls1,
  input  logic                 wide1,
  input  logic [NUM_ITER-1:0]  unitBusy,
  output logic                 grant0,
  output logic                 grant1,
  output logic [NUM_PORTS-1:0] port0,
  output logic [NUM_PORTS-1:0] port1,
  output logic                 stall,
  output iterStrobe_t          strobe
);

  logic [1:0]       vld;
  logic [1:0]       wd;
  logic [1:0]       blk;
  logic [1:0]       grant;
  logic [CLS_W-1:0] cls [2];
  logic             crossA;
  logic             crossB;

  assign vld    = {valid1, valid0};
  assign wd     = {wide1, wide0};
  assign cls[0] = cls0;
  assign cls[1] = cls1;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign blk[s] = |(unitMask(cls[s]) & unitBusy);
  end

  always_comb begin
    crossA   = memOk(cls0) & fOk(cls1);
    crossB   = fOk(cls0) & memOk(cls1);
    grant[0] = vld[0] & ~blk[0];
    grant[1] = grant[0] & vld[1] & ~blk[1]
             & ~isSerial(cls0) & ~isSerial(cls1)
             & (instClass_e'(cls0) != CLS_BRANCH)
             & (crossA | crossB);
  end

  always_comb begin
    port0 = '0;
    port1 = '0;
    if (grant[1]) begin
      if (crossA) begin
        port0[P_MEM] = 1'b1;
        port1        = fPortVec(cls1);
      end else begin
        port0        = fPortVec(cls0);
        port1[P_MEM] = 1'b1;
      end
    end else if (grant[0]) begin
      if (isSerial(cls0))   port0[P_SOLO] = 1'b1;
      else if (memOk(cls0)) port0[P_MEM]  = 1'b1;
      else                  port0         = fPortVec(cls0);
    end
  end

  always_comb begin
    strobe = '0;
    for (int s = 0; s < 2; s++) begin
      if (grant[s]) begin
        strobe.load = strobe.load | loadMask(cls[s]);
        if (longKind(cls[s])) strobe.kind = strobe.kind | loadMask(cls[s]);
        if (wd[s])            strobe.wide = strobe.wide | loadMask(cls[s]);
      end
    end
  end

  assign grant0 = grant[0];
  assign grant1 = grant[1];
  assign stall  = (vld[0] & ~grant[0]) | (vld[1] & ~grant[1]);

endmodule

// File: rtl/iter_busy.sv
module iter_busy
  import dual_issue_pkg::*;
#(
  parameter int LAT_MUL32  = 3,
  parameter int LAT_MUL64  = 8,
  parameter int LAT_DIV32  = 36,
  parameter int LAT_DIV64  = 68,
  parameter int LAT_FDIV_S = 21,
  parameter int LAT_FDIV_D = 36,
  parameter int LAT_FRSQ_S = 38,
  parameter int LAT_FRSQ_D = 68,
  parameter int LAT_FMUL_S = 1,
  parameter int LAT_FMUL_D = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  iterStrobe_t         strobe,
  output logic [NUM_ITER-1:0] unitBusy
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_MD  = maxOf(maxOf(LAT_MUL32, LAT_MUL64), maxOf(LAT_DIV32, LAT_DIV64));
  localparam int MAX_FD  = maxOf(maxOf(LAT_FDIV_S, LAT_FDIV_D), maxOf(LAT_FRSQ_S, LAT_FRSQ_D));
  localparam int MAX_FM  = maxOf(LAT_FMUL_S, LAT_FMUL_D);
  localparam int MAX_LAT = maxOf(maxOf(MAX_MD, MAX_FD), MAX_FM);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  for (genvar u = 0; u < NUM_ITER; u++) begin : g_unit
    // Latency for {kind, wide}: kind selects divide / reciprocal sqrt.
    localparam int L_SHORT_N = (u == ITER_MD) ? LAT_MUL32 : (u == ITER_FD) ? LAT_FDIV_S : LAT_FMUL_S;
    localparam int L_SHORT_W = (u == ITER_MD) ? LAT_MUL64 : (u == ITER_FD) ? LAT_FDIV_D : LAT_FMUL_D;
    localparam int L_LONG_N  = (u == ITER_MD) ? LAT_DIV32 : (u == ITER_FD) ? LAT_FRSQ_S : LAT_FMUL_S;
    localparam int L_LONG_W  = (u == ITER_MD) ? LAT_DIV64 : (u == ITER_FD) ? LAT_FRSQ_D : LAT_FMUL_D;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] loadVal;

    always_comb begin
      case ({strobe.kind[u], strobe.wide[u]})
        2'b00:   loadVal = CNT_W'(L_SHORT_N);
        2'b01:   loadVal = CNT_W'(L_SHORT_W);
        2'b10:   loadVal = CNT_W'(L_LONG_N);
        default: loadVal = CNT_W'(L_LONG_W);
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cnt <= '0;
      else if (strobe.load[u])  cnt <= loadVal;
      else if (cnt != '0)       cnt <= cnt - CNT_W'(1);
    end

    assign unitBusy[u] = (cnt != '0);
  end

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
#(
  parameter int LAT_MUL32  = 3,
  parameter int LAT_MUL64  = 8,
  parameter int LAT_DIV32  = 36,
  parameter int LAT_DIV64  = 68,
  parameter int LAT_FDIV_S = 21,
  parameter int LAT_FDIV_D = 36,
  parameter int LAT_FRSQ_S = 38,
  parameter int LAT_FRSQ_D = 68,
  parameter int LAT_FMUL_S = 1,
  parameter int LAT_FMUL_D = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 valid0,
  input  logic [CLS_W-1:0]     class0,
  input  logic                 wide0,
  input  logic                 valid1,
  input  logic [CLS_W-1:0]     class1,
  input  logic                 wide1,
  output logic                 grant0,
  output logic                 grant1,
  output logic [NUM_PORTS-1:0] port0,
  output logic [NUM_PORTS-1:0] port1,
  output logic                 stall,
  output logic [NUM_ITER-1:0]  unitBusy
);

  iterStrobe_t strobe;

  issue_ctrl u_ctrl (
    .valid0   (valid0),
    .cls0     (class0),
    .wide0    (wide0),
    .valid1   (valid1),
    .cls1     (class1),
    .wide1    (wide1),
    .unitBusy (unitBusy),
    .grant0   (grant0),
    .grant1   (grant1),
    .port0    (port0),
    .port1    (port1),
    .stall    (stall),
    .strobe   (strobe)
  );

  iter_busy #(
    .LAT_MUL32  (LAT_MUL32),
    .LAT_MUL64  (LAT_MUL64),
    .LAT_DIV32  (LAT_DIV32),
    .LAT_DIV64  (LAT_DIV64),
    .LAT_FDIV_S (LAT_FDIV_S),
    .LAT_FDIV_D (LAT_FDIV_D),
    .LAT_FRSQ_S (LAT_FRSQ_S),
    .LAT_FRSQ_D (LAT_FRSQ_D),
    .LAT_FMUL_S (LAT_FMUL_S),
    .LAT_FMUL_D (LAT_FMUL_D)
  ) u_busy (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .unitBusy (unitBusy)
  );

endmodule

// File: rtl/dual_issue_chk.sv
module dual_issue_chk
  import dual_issue_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 valid0,
  input logic [CLS_W-1:0]     class0,
  input logic                 wide0,
  input logic                 valid1,
  input logic [CLS_W-1:0]     class1,
  input logic                 wide1,
  input logic                 grant0,
  input logic                 grant1,
  input logic [NUM_PORTS-1:0] port0,
  input logic [NUM_PORTS-1:0] port1,
  input logic                 stall,
  input logic [NUM_ITER-1:0]  unitBusy
);

  localparam logic [NUM_PORTS-1:0] OTHER_PIPE = 8'h7E;

  logic mdStart;
  assign mdStart = (grant0 && (class0 == CLS_IMUL || class0 == CLS_IDIV))
                || (grant1 && (class1 == CLS_IMUL || class1 == CLS_IDIV));

  assert_port_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    grant0 |-> ($countones(port0) == 1));

  assert_port_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !grant1 |-> (port1 == '0));

  assert_in_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    grant1 |-> grant0);

  assert_mem_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    (grant0 && port0[P_MEM]) |-> memOk(class0));

  assert_other_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones((port0 | port1) & OTHER_PIPE) <= 1);

  assert_branch_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    (grant0 && class0 == CLS_BRANCH) |-> !grant1);

  assert_serial_alone_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grant0 && isSerial(class0)) |-> (!grant1 && port0[P_SOLO]));

  assert_md_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (unitBusy[ITER_MD] && valid0 && unitMask(class0)[ITER_MD]) |-> !grant0);

  assert_md_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unitBusy[ITER_MD]) |-> $past(mdStart));

  assert_fd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (unitBusy[ITER_FD] && valid0 && (class0 == CLS_FDIV || class0 == CLS_FRSQRT)) |-> !grant0);

  assert_fm_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (unitBusy[ITER_FM] && valid1 && class1 == CLS_FMUL) |-> !grant1);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (unitBusy == '0));

  assert_hilo_port_R11: assert property (@(posedge clk) disable iff (!rstN)
    (grant0 && !grant1 && class0 == CLS_HILO) |-> port0[P_MD]);

endmodule

bind dual_issue_ctrl dual_issue_chk u_chk (.*);

// File: tb/dual_issue_ctrl_tb.sv
module dual_issue_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int L_MUL32 = 3,  L_MUL64 = 8,  L_DIV32 = 36, L_DIV64 = 68;
  localparam int L_FDS   = 21, L_FDD   = 36, L_FRS   = 38, L_FRD   = 68;
  localparam int L_FMS   = 1,  L_FMD   = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       valid0 = 1'b0, valid1 = 1'b0, wide0 = 1'b0, wide1 = 1'b0;
  logic [3:0] class0 = '0, class1 = '0;
  logic       grant0, grant1, stall;
  logic [7:0] port0, port1;
  logic [2:0] unitBusy;

  int nVec  = 0;
  int nFail = 0;
  int cnt [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_ctrl #(
    .LAT_MUL32(L_MUL32), .LAT_MUL64(L_MUL64), .LAT_DIV32(L_DIV32), .LAT_DIV64(L_DIV64),
    .LAT_FDIV_S(L_FDS), .LAT_FDIV_D(L_FDD), .LAT_FRSQ_S(L_FRS), .LAT_FRSQ_D(L_FRD),
    .LAT_FMUL_S(L_FMS), .LAT_FMUL_D(L_FMD)
  ) u_dut (
    .clk(clk), .rstN(rstN),
    .valid0(valid0), .class0(class0), .wide0(wide0),
    .valid1(valid1), .class1(class1), .wide1(wide1),
    .grant0(grant0), .grant1(grant1), .port0(port0), .port1(port1),
    .stall(stall), .unitBusy(unitBusy)
  );

  // ---- reference model, written from the requirements ----
  function automatic bit mMem(int c);    return c <= 3; endfunction
  function automatic bit mSerial(int c); return c >= 14; endfunction
  function automatic bit mOther(int c);  return !(c == 1 || c == 2 || c >= 14); endfunction

  function automatic int mPortBit(int c);
    if (c == 0 || c == 3) return 1;
    if (c == 7)           return 2;
    if (c >= 4 && c <= 6) return 3;
    if (c >= 8 && c <= 10) return 4;
    if (c == 11)          return 5;
    if (c == 12 || c == 13) return 6;
    return 7;
  endfunction

  function automatic int mUnit(int c);
    if (c >= 4 && c <= 6)   return 0;
    if (c == 12 || c == 13) return 1;
    if (c == 11)            return 2;
    return -1;
  endfunction

  function automatic int mLat(int c, bit w);
    case (c)
      4:  return w ? L_MUL64 : L_MUL32;
      5:  return w ? L_DIV64 : L_DIV32;
      11: return w ? L_FMD   : L_FMS;
      12: return w ? L_FDD   : L_FDS;
      13: return w ? L_FRD   : L_FRS;
      default: return 0;
    endcase
  endfunction

  function automatic bit mHeld(int c);
    int u;
    u = mUnit(c);
    return (u >= 0) && (cnt[u] > 0);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v0, int c0, bit w0, bit v1, int c1, bit w1);
    bit e0, e1, a, b;
    logic [7:0] p0, p1;
    logic [2:0] eb;
    @(negedge clk);
    valid0 = v0; class0 = 4'(c0); wide0 = w0;
    valid1 = v1; class1 = 4'(c1); wide1 = w1;
    #1;
    a  = mMem(c0) && mOther(c1);
    b  = mOther(c0) && mMem(c1);
    e0 = v0 && !mHeld(c0);
    e1 = e0 && v1 && !mHeld(c1) && !mSerial(c0) && !mSerial(c1) && (c0 != 7) && (a || b);
    p0 = '0; p1 = '0;
    if (e1) begin
      if (a) begin p0[0] = 1'b1; p1[mPortBit(c1)] = 1'b1; end
      else   begin p0[mPortBit(c0)] = 1'b1; p1[0] = 1'b1; end
    end else if (e0) begin
      if (mSerial(c0)) p0[7] = 1'b1;
      else if (mMem(c0)) p0[0] = 1'b1;
      else p0[mPortBit(c0)] = 1'b1;
    end
    for (int u = 0; u < 3; u++) eb[u] = (cnt[u] > 0);
    cmp(tag, "grant0", int'(grant0), int'(e0));
    cmp(tag, "grant1", int'(grant1), int'(e1));
    cmp(tag, "port0", int'(port0), int'(p0));
    cmp(tag, "port1", int'(port1), int'(p1));
    cmp(tag, "stall", int'(stall), int'((v0 && !e0) || (v1 && !e1)));
    cmp(tag, "unitBusy", int'(unitBusy), int'(eb));
    for (int u = 0; u < 3; u++) if (cnt[u] > 0) cnt[u]--;
    if (e0 && mLat(c0, w0) > 0) cnt[mUnit(c0)] = mLat(c0, w0);
    if (e1 && mLat(c1, w1) > 0) cnt[mUnit(c1)] = mLat(c1, w1);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    valid0 = 1'b0; valid1 = 1'b0;
    for (int u = 0; u < 3; u++) cnt[u] = 0;
    repeat (2) @(negedge clk);
    cmp("R10", "unitBusy in reset", int'(unitBusy), 0);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    doReset();
    idle("R10", 2);

    // R2: in-order issue and stall
    step("R2", 0, 0, 0, 1, 0, 0);
    step("R2", 1, 1, 0, 1, 2, 0);

    // R3: memory pipe and pairing preference
    step("R3", 1, 1, 0, 1, 0, 0);
    step("R3", 1, 0, 0, 1, 1, 0);
    step("R3", 1, 0, 0, 1, 0, 0);
    step("R3", 1, 3, 0, 1, 2, 0);
    step("R3", 1, 3, 0, 0, 0, 0);
    step("R3", 1, 2, 0, 1, 9, 0);

    // R4: other pipe exclusivity and port map
    step("R4", 1, 9, 0, 1, 4, 0);
    step("R4", 1, 8, 0, 1, 10, 0);
    step("R4", 1, 10, 0, 1, 0, 0);
    step("R4", 1, 0, 0, 1, 11, 0);
    step("R4", 1, 12, 0, 1, 1, 0);
    idle("R4", 25);

    // R5: branch closes the group
    step("R5", 1, 7, 0, 1, 0, 0);
    step("R5", 1, 0, 0, 1, 7, 0);
    step("R5", 1, 1, 0, 1, 7, 0);
    step("R5", 1, 7, 0, 1, 9, 0);

    // R6: serialising classes
    step("R6", 1, 14, 0, 1, 0, 0);
    step("R6", 1, 0, 0, 1, 14, 0);
    step("R6", 1, 15, 0, 0, 0, 0);
    step("R6", 1, 3, 0, 1, 15, 0);

    // R7: multiply/divide unit windows, issued back to back
    for (int i = 0; i < 75; i++)  step("R7", 1, 5, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++)  step("R7", 1, 5, 0, 1, 1, 0);
    for (int i = 0; i < 12; i++)  step("R7", 1, 4, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++)  step("R7", 1, 0, 0, 1, 4, 1);
    idle("R7", 10);

    // R11: HI/LO move held by the busy unit and does not occupy it
    step("R11", 1, 4, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R11", 1, 6, 0, 0, 0, 0);
    step("R11", 1, 1, 0, 1, 6, 0);
    step("R11", 1, 6, 0, 1, 5, 0);

    // R8: FP divide/sqrt unit windows
    for (int i = 0; i < 75; i++) step("R8", 1, 13, 1, 0, 0, 0);
    for (int i = 0; i < 45; i++) step("R8", 1, 13, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step("R8", 1, 12, 1, 0, 0, 0);
    for (int i = 0; i < 25; i++) step("R8", 1, 0, 0, 1, 12, 0);
    idle("R8", 70);

    // R9: FP multiply unit windows
    for (int i = 0; i < 6; i++) step("R9", 1, 11, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step("R9", 1, 11, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R9", 1, 1, 0, 1, 11, 0);

    // R10: reset in the middle of a long busy period
    step("R10", 1, 5, 1, 1, 0, 0);
    step("R10", 1, 12, 1, 0, 0, 0);
    idle("R10", 3);
    doReset();
    step("R10", 1, 5, 0, 1, 0, 0);

    // R1: mixed pseudo-random traffic across all encodings
    for (int i = 0; i < 5000; i++) begin
      step("R1", 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule